// File: doc/BRIEF.md
# Column-Shift Spare Remapping Controller

This controller sits beside a two-dimensional array of identical processing elements. Its job is to keep a working assignment of logical columns onto physical columns. When the array comes out of reset, the leftmost physical columns carry the logical columns in order. The rightmost columns are held in reserve, and no logical column is mapped to them.

A per-element self-test reports that an element is going bad before it actually stops working. The report gives the element's row and column. On such a report, the controller retires the whole physical column that holds the element, whatever the row. The logical column that was placed there, and every logical column to its right, then moves one healthy physical column to the right. In this way each avoided fault uses up exactly one reserve column.

The controller drives three things from registers:
- a bypass-enable vector, one bit per physical column, for the horizontal routing;
- the logical-to-physical column table;
- a status readout: the number of avoided faults, the number of reserve columns left, and a device-failed flag.

When a report lands on a used column and no reserve column is left, avoidance fails. The device is then declared failed, and the state stays frozen until reset.

Top module: `col_spare_remap`

## Requirements
- R1: After synchronous reset, the controller is in its initial state:
  - logical column i maps to physical column i;
  - `bypass_en` is all zero;
  - `spares_left` equals the reserve count (3 by default);
  - `avoided_cnt` is 0;
  - `dev_failed` is 0;
  - `upd_done` is 0.
- R2: A report whose column holds a logical column, while a reserve remains, has these effects:
  - it sets that column's bit in `bypass_en` (bit p stands for physical column p);
  - logical columns to the left keep their place;
  - that logical column and each one to its right move to the next physical column on the right whose `bypass_en` bit is clear.
  - Logical column i sits in `map_phys[i*3 +: 3]`.
- R3: The row field of a report has no effect on the outcome. A fault in any row retires the whole physical column.
- R4: Each avoided fault raises `avoided_cnt` by one and lowers `spares_left` by one.
- R5: A report that changes nothing is still acknowledged. This applies to a report naming:
  - a reserve column with nothing mapped to it;
  - an already retired column;
  - a column index of 6 or more.
- R6: Every report presented with `flt_valid` high for one cycle produces `upd_done` high in exactly the next cycle. `upd_done` is low in the cycle after that, and all outputs already show the updated state in the cycle where `upd_done` is high.
- R7: A report on a mapped column when `spares_left` is 0 has these effects:
  - it sets `dev_failed`;
  - it leaves `avoided_cnt`, `map_phys` and `bypass_en` unchanged.
- R8: Once `dev_failed` is set, it stays set, and no later report changes any output other than `upd_done`, until reset.
- R9: Asserting reset after faults and failure brings back the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | Fault report strobe, one cycle per report |
| flt_row | input | 3 | Row of the reported element |
| flt_col | input | 3 | Physical column of the reported element |
| upd_done | output | 1 | One-cycle acknowledge of a processed report |
| bypass_en | output | 6 | Per-physical-column bypass select (1 = retired) |
| map_phys | output | 9 | Physical column of each logical column, 3 bits each |
| avoided_cnt | output | 2 | Number of avoided faults |
| spares_left | output | 2 | Reserve columns still unused |
| dev_failed | output | 1 | Avoidance failed; device declared dead |

## Verification
The bench retires column 1, the middle column, and then column 0. This checks that columns left of the fault stay put. A mapper that shifted every column, or that shifted by the raw index instead of skipping retired columns, would show a wrong `map_phys`.

Several reports are aimed at columns that must change nothing:
- an unused reserve column;
- a retired column;
- an out-of-range index.

A controller that let any of these through would burn a reserve or move the map, and the bench would see it.

The last reserve is used up by a fault on the rightmost mapped column. The next report must set the failed flag while freezing the count and the table. A design that wrapped the counter or went on shifting after failure would change outputs that must hold.

Two otherwise identical faults are sent after separate resets, one in row 0 and one in row 5. This exposes any dependence on the row.

// File: rtl/remap_pkg.sv
package remap_pkg;
  // Outcome of one fault report after classification
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_RETIRE = 2'd1,
    ACT_FAIL   = 2'd2
  } remap_act_e;
endpackage

// File: rtl/remap_mapper.sv
// Combinational placement: logical column i lands on the i-th healthy physical column.
module remap_mapper #(
  parameter int COLS = 6,
  parameter int LOGC = 3,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int SW  = $clog2(COLS - LOGC + 1)
) (
  input  logic [COLS-1:0]    retired,
  output logic [LOGC*CW-1:0] map_o,
  output logic [COLS-1:0]    mapped_o,
  output logic [SW-1:0]      spares_o
);
  int rank;

  always_comb begin
    map_o    = '0;
    mapped_o = '0;
    rank     = 0;
    for (int p = 0; p < COLS; p++) begin
      if (!retired[p]) begin
        if (rank < LOGC) begin
          map_o[rank*CW +: CW] = CW'(p);
          mapped_o[p]          = 1'b1;
        end
        rank = rank + 1;
      end
    end
    spares_o = (rank >= LOGC) ? SW'(rank - LOGC) : '0;
  end
endmodule

// File: rtl/remap_classifier.sv
// Decides what a fault report does to the mapping.
module remap_classifier
  import remap_pkg::*;
#(
  parameter int COLS = 6,
  parameter int LOGC = 3,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int SW  = $clog2(COLS - LOGC + 1)
) (
  input  logic            flt_valid,
  input  logic [CW-1:0]   flt_col,
  input  logic [COLS-1:0] mapped,
  input  logic [SW-1:0]   spares,
  input  logic            failed,
  output remap_act_e      act
);
  logic in_range;
  logic hits_used;

  assign in_range  = (int'(flt_col) < COLS);
  assign hits_used = in_range && mapped[flt_col];

  always_comb begin
    act = ACT_NONE;
    if (flt_valid && !failed && hits_used) begin
      act = (spares != '0) ? ACT_RETIRE : ACT_FAIL;
    end
  end
endmodule

// File: rtl/remap_state.sv
// Holds retirement state, the registered map and status.
module remap_state
  import remap_pkg::*;
#(
  parameter int COLS = 6,
  parameter int LOGC = 3,
  localparam int NSPR = COLS - LOGC,
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int SW   = $clog2(NSPR + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flt_valid,
  input  logic [CW-1:0]      flt_col,
  input  remap_act_e         act,
  output logic [COLS-1:0]    retired_q,
  output logic [COLS-1:0]    mapped_q,
  output logic [LOGC*CW-1:0] map_q,
  output logic [SW-1:0]      spares_q,
  output logic [SW-1:0]      cnt_q,
  output logic               failed_q,
  output logic               done_q
);
  logic [COLS-1:0]    retired_d;
  logic [LOGC*CW-1:0] map_d;
  logic [COLS-1:0]    mapped_d;
  logic [SW-1:0]      spares_d;

  // one flop per physical column retirement flag
  for (genvar p = 0; p < COLS; p++) begin : g_ret
    assign retired_d[p] = retired_q[p] ||
                          ((act == ACT_RETIRE) && (int'(flt_col) == p));
    always_ff @(posedge clk) begin
      if (rst) retired_q[p] <= 1'b0;
      else     retired_q[p] <= retired_d[p];
    end
  end

  remap_mapper #(.COLS(COLS), .LOGC(LOGC)) u_mapper (
    .retired  (retired_d),
    .map_o    (map_d),
    .mapped_o (mapped_d),
    .spares_o (spares_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q    <= '0;
      for (int i = 0; i < LOGC; i++) map_q[i*CW +: CW] <= CW'(i);
      mapped_q <= COLS'((1 << LOGC) - 1);
      spares_q <= SW'(NSPR);
      cnt_q    <= '0;
      failed_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      map_q    <= map_d;
      mapped_q <= mapped_d;
      spares_q <= spares_d;
      done_q   <= flt_valid;
      if (act == ACT_RETIRE) cnt_q    <= cnt_q + 1'b1;
      if (act == ACT_FAIL)   failed_q <= 1'b1;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt_q) + int'(spares_q)) == NSPR);

  // R6
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    flt_valid |=> done_q);

  // R8
  failed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    failed_q |=> (failed_q && $stable(cnt_q) && $stable(map_q)));

  // R2
  retire_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((retired_q & $past(retired_q)) == $past(retired_q)));

  // R2
  one_retire_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($countones(retired_q ^ $past(retired_q)) <= 1));

  // R7
  fail_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_FAIL) |=> ($stable(retired_q) && $stable(cnt_q)));
endmodule

// File: rtl/col_spare_remap.sv
module col_spare_remap
  import remap_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int COLS = 6,
  parameter int NSPR = 3,
  localparam int LOGC = COLS - NSPR,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int SW   = $clog2(NSPR + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flt_valid,
  input  logic [RW-1:0]      flt_row,
  input  logic [CW-1:0]      flt_col,
  output logic               upd_done,
  output logic [COLS-1:0]    bypass_en,
  output logic [LOGC*CW-1:0] map_phys,
  output logic [SW-1:0]      avoided_cnt,
  output logic [SW-1:0]      spares_left,
  output logic               dev_failed
);
  remap_act_e      act;
  logic [COLS-1:0] mapped_q;
  logic [RW-1:0]   row_unused;

  // a fault in any row retires the whole column
  assign row_unused = flt_row;

  remap_classifier #(.COLS(COLS), .LOGC(LOGC)) u_class (
    .flt_valid (flt_valid),
    .flt_col   (flt_col),
    .mapped    (mapped_q),
    .spares    (spares_left),
    .failed    (dev_failed),
    .act       (act)
  );

  remap_state #(.COLS(COLS), .LOGC(LOGC)) u_state (
    .clk       (clk),
    .rst       (rst),
    .flt_valid (flt_valid),
    .flt_col   (flt_col),
    .act       (act),
    .retired_q (bypass_en),
    .mapped_q  (mapped_q),
    .map_q     (map_phys),
    .spares_q  (spares_left),
    .cnt_q     (avoided_cnt),
    .failed_q  (dev_failed),
    .done_q    (upd_done)
  );

  // R5
  unused_col_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && (int'(flt_col) < COLS) && !mapped_q[flt_col]) |=>
      $stable(bypass_en));
endmodule

// File: tb/col_spare_remap_bench.sv
module col_spare_remap_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       flt_valid;
  logic [2:0] flt_row;
  logic [2:0] flt_col;
  logic       upd_done;
  logic [5:0] bypass_en;
  logic [8:0] map_phys;
  logic [1:0] avoided_cnt;
  logic [1:0] spares_left;
  logic       dev_failed;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  col_spare_remap u_col_spare_remap (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_row(flt_row),
    .flt_col(flt_col), .upd_done(upd_done), .bypass_en(bypass_en),
    .map_phys(map_phys), .avoided_cnt(avoided_cnt),
    .spares_left(spares_left), .dev_failed(dev_failed)
  );

  function automatic logic [8:0] mk_map(int a, int b, int c);
    return {3'(c), 3'(b), 3'(a)};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req, logic [8:0] m, logic [5:0] b,
                           int cnt, int spr, logic fl);
    chk({req, " map"},    16'(map_phys),    16'(m));
    chk({req, " bypass"}, 16'(bypass_en),   16'(b));
    chk({req, " count"},  16'(avoided_cnt), 16'(cnt));
    chk({req, " spares"}, 16'(spares_left), 16'(spr));
    chk({req, " failed"}, 16'(dev_failed),  16'(fl));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; flt_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one-cycle report; returns after the acknowledge cycle is checked (R6)
  task automatic send(int row, int col);
    @(negedge clk);
    flt_valid = 1'b1; flt_row = 3'(row); flt_col = 3'(col);
    @(negedge clk);
    flt_valid = 1'b0;
    chk("R6 done high", 16'(upd_done), 16'd1);
    @(negedge clk);
    chk("R6 done low", 16'(upd_done), 16'd0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 done", 16'(upd_done), 16'd0);
    chk_state("R1", mk_map(0, 1, 2), 6'b000000, 0, 3, 1'b0);
  endtask

  task automatic t_shift_and_ignore();
    send(4, 1);
    chk_state("R2 R4 first", mk_map(0, 2, 3), 6'b000010, 1, 2, 1'b0);
    send(2, 5);
    chk_state("R5 reserve col", mk_map(0, 2, 3), 6'b000010, 1, 2, 1'b0);
    send(0, 1);
    chk_state("R5 retired col", mk_map(0, 2, 3), 6'b000010, 1, 2, 1'b0);
    send(3, 7);
    chk_state("R5 out of range", mk_map(0, 2, 3), 6'b000010, 1, 2, 1'b0);
    send(0, 0);
    chk_state("R2 R4 second", mk_map(2, 3, 4), 6'b000011, 2, 1, 1'b0);
    send(5, 4);
    chk_state("R2 R4 third", mk_map(2, 3, 5), 6'b010011, 3, 0, 1'b0);
  endtask

  task automatic t_fail();
    send(1, 3);
    chk_state("R7 exhausted", mk_map(2, 3, 5), 6'b010011, 3, 0, 1'b1);
    send(0, 2);
    chk_state("R8 after fail", mk_map(2, 3, 5), 6'b010011, 3, 0, 1'b1);
    send(0, 5);
    chk_state("R8 after fail 2", mk_map(2, 3, 5), 6'b010011, 3, 0, 1'b1);
  endtask

  task automatic t_rows();
    do_reset();
    chk_state("R9 restore", mk_map(0, 1, 2), 6'b000000, 0, 3, 1'b0);
    send(0, 2);
    chk_state("R3 row0", mk_map(0, 1, 3), 6'b000100, 1, 2, 1'b0);
    do_reset();
    send(5, 2);
    chk_state("R3 row5", mk_map(0, 1, 3), 6'b000100, 1, 2, 1'b0);
  endtask

  initial begin
    rst = 1'b1; flt_valid = 1'b0; flt_row = '0; flt_col = '0;
    t_reset();
    t_shift_and_ignore();
    t_fail();
    t_rows();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule